// File: doc/BRIEF.md
# Receive L4 Checksum Verifier

This block sits in the receive path of an Ethernet port. It watches a byte stream of received frames and, for frames that carry IPv4 or IPv6 with a TCP or UDP segment, it forms the pseudo-header and sums the segment in ones'-complement arithmetic. The sum is built while the frame goes past. Nothing is stored and the data is not changed. The frame bytes are forwarded to the output after one register stage. One status word comes out beside the last forwarded beat.

The status word is packed. It holds the folded 16-bit sum and flags for IPv4, IPv6, TCP, fragmented packet and checksum error. Downstream logic can therefore both trust the verdict and reuse the raw sum. A control input turns verification off. While it is off, the status word is all zero. VLAN tags and IPv6 extension headers are not parsed. An IPv6 next-header value other than TCP or UDP counts as an unsupported protocol.

Top module: `rxck_l4_verify`

## Requirements
- R1: Every input beat appears on the output exactly one cycle later, with data, start and end flags unchanged. A cycle without an input beat gives a cycle without an output beat.
- R2: `stat_valid` is high for exactly one cycle: the cycle after the input beat that carries the end flag. It coincides with the forwarded last beat.
- R3: A frame is IPv4 when frame bytes 12..13 hold 0x0800, the upper nibble of byte 14 is 4 and its lower nibble (header length in 32-bit words) is at least 5. This sets status bit 20. A frame is IPv6 when bytes 12..13 hold 0x86DD and the upper nibble of byte 14 is 6. This sets status bit 19. If the version nibble does not match the type field, the frame is not IP.
- R4: The protocol byte (IPv4 byte 23, IPv6 byte 20) selects TCP (6) or UDP (17). Status bit 18 is set for TCP only. Any other protocol value gives an all-zero status word.
- R5: Status bits 15:0 carry the folded ones'-complement sum of the 16-bit big-endian words of the source and destination addresses, the protocol value, the L4 length and the L4 bytes. An odd final byte is padded with zero. Bytes past the L4 length are excluded. A correct segment yields 0xFFFF.
- R6: Status bit 16 (error) is set when the folded sum is not 0xFFFF.
- R7: For UDP over IPv4 whose checksum field (L4 bytes 6..7) is zero, bit 16 stays clear. UDP over IPv6 gets no such exemption.
- R8: An IPv4 packet with the more-fragments flag set (byte 20 bit 5) or a nonzero fragment offset (byte 20 bits 4:0, byte 21) sets status bit 17. It then leaves bit 16 and bits 15:0 at zero, and the IP and TCP flags are still reported. The don't-fragment flag alone is not a fragment.
- R9: A frame of another type, or one whose end beat falls at or before the last destination-address byte, gives an all-zero status word.
- R10: When `chk_en` is low on the end beat, the status word is all zero.
- R11: For IPv4, the L4 segment starts at byte 14 + 4 × header length and its length is the total length minus 4 × header length. For IPv6, the segment starts at byte 54 and its length is the payload length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Verification enable, sampled on the end beat |
| s_valid | input | 1 | Input beat valid |
| s_sof | input | 1 | Input beat is the first byte of a frame |
| s_eof | input | 1 | Input beat is the last byte of a frame |
| s_data | input | 8 | Input frame byte |
| m_valid | output | 1 | Forwarded beat valid |
| m_sof | output | 1 | Forwarded first-byte flag |
| m_eof | output | 1 | Forwarded last-byte flag |
| m_data | output | 8 | Forwarded frame byte |
| stat_valid | output | 1 | Status word strobe |
| stat_word | output | 21 | Packed status: error, fragment, TCP, IPv6, IPv4 flags and folded sum |

## Verification
Correctly checksummed segments over both IP versions and both transports must give 0xFFFF with no error. Single corrupted payload bytes must move the sum and raise the error. Together these separate a right adder and pseudo-header from one that only happens to pass. Zero UDP checksums on IPv4 and on IPv6 show that the exemption is tied to the right version. Fragments flagged either by the more-fragments bit or by the offset show that both fields are decoded and that a set don't-fragment bit is not mistaken for one. Header options, odd segment lengths, trailing padding, truncated frames, foreign types, version mismatches, other protocols and the enable being off cover the window and classification corner cases. A seeded random mix covers lengths and addresses.

// File: rtl/rxck_pkg.sv
package rxck_pkg;
   localparam int BYTE_W = 8;
   localparam int STAT_W = 21;

   // status word bit positions (decoded downstream)
   localparam int B_ERR  = 16;
   localparam int B_FRAG = 17;
   localparam int B_TCP  = 18;
   localparam int B_V6   = 19;
   localparam int B_V4   = 20;

   localparam logic [15:0] ET_V4 = 16'h0800;
   localparam logic [15:0] ET_V6 = 16'h86DD;
   localparam logic [7:0]  PR_TCP = 8'd6;
   localparam logic [7:0]  PR_UDP = 8'd17;

   // frame byte positions
   localparam int L2_LEN   = 14;
   localparam int V4_ADDR0 = 26;
   localparam int V4_ADDR1 = 33;
   localparam int V6_ADDR0 = 22;
   localparam int V6_ADDR1 = 53;
   localparam int V6_L4    = 54;

   typedef enum logic [1:0] {NET_NONE, NET_V4, NET_V6} net_e;
endpackage

// File: rtl/rxck_hdr_parse.sv
module rxck_hdr_parse
   import rxck_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic              sof,
   input  logic [BYTE_W-1:0] d,
   output logic              add_en,
   output logic              add_hi,
   output net_e              net,
   output logic [7:0]        proto,
   output logic [15:0]       l4_len,
   output logic              frag,
   output logic              hdr_ok,
   output logic              ck_nz
);
   localparam int PW = ((CNT_W > 16) ? CNT_W : 16) + 1;

   logic [CNT_W-1:0] idx_r, idx;
   logic [PW-1:0]    ix, l4_start, l4_end;
   logic [7:0]       et_hi;
   net_e             net_r;
   logic [3:0]       ihl_r;
   logic [15:0]      len_r;
   logic [7:0]       proto_r;
   logic             frag_r, hdr_r, cknz_r;
   logic [5:0]       hdr_bytes;
   logic             in_addr, in_l4, ck_hit;

   assign idx       = sof ? '0 : idx_r;
   assign ix        = PW'(idx);
   assign hdr_bytes = {ihl_r, 2'b00};
   assign l4_start  = (net_r == NET_V6) ? PW'(V6_L4) : PW'(L2_LEN) + PW'(hdr_bytes);
   assign l4_len    = (net_r == NET_V4) ? len_r - 16'(hdr_bytes) : len_r;
   assign l4_end    = l4_start + PW'(l4_len);

   assign in_addr = (net_r == NET_V4 && ix >= PW'(V4_ADDR0) && ix <= PW'(V4_ADDR1)) ||
                    (net_r == NET_V6 && ix >= PW'(V6_ADDR0) && ix <= PW'(V6_ADDR1));
   assign in_l4   = hdr_r && !sof && ix >= l4_start && ix < l4_end;
   assign ck_hit  = in_l4 && (ix == l4_start + PW'(6) || ix == l4_start + PW'(7)) && (d != '0);

   assign add_en = beat && (in_addr || in_l4);
   assign add_hi = ~idx[0];
   assign ck_nz  = (!sof && cknz_r) || (beat && ck_hit);
   assign net    = net_r;
   assign proto  = proto_r;
   assign frag   = frag_r;
   assign hdr_ok = hdr_r && !sof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_r <= '0; et_hi <= '0; net_r <= NET_NONE; ihl_r <= '0; len_r <= '0;
         proto_r <= '0; frag_r <= 1'b0; hdr_r <= 1'b0; cknz_r <= 1'b0;
      end else if (beat) begin
         idx_r  <= (&idx) ? idx : idx + 1'b1;
         cknz_r <= ck_nz;
         if (sof) begin
            net_r <= NET_NONE; ihl_r <= '0; len_r <= '0; proto_r <= '0;
            frag_r <= 1'b0; hdr_r <= 1'b0;
         end else begin
            if (ix == PW'(12)) et_hi <= d;
            if (ix == PW'(13))
               net_r <= ({et_hi, d} == ET_V4) ? NET_V4 :
                        ({et_hi, d} == ET_V6) ? NET_V6 : NET_NONE;
            if (ix == PW'(14)) begin
               if (net_r == NET_V4) begin
                  ihl_r <= d[3:0];
                  if (d[7:4] != 4'd4 || d[3:0] < 4'd5) net_r <= NET_NONE;
               end
               if (net_r == NET_V6 && d[7:4] != 4'd6) net_r <= NET_NONE;
            end
            if (net_r == NET_V4) begin
               if (ix == PW'(16)) len_r[15:8] <= d;
               if (ix == PW'(17)) len_r[7:0]  <= d;
               if (ix == PW'(20)) frag_r <= d[5] || (d[4:0] != '0);
               if (ix == PW'(21)) frag_r <= frag_r || (d != '0);
               if (ix == PW'(23)) proto_r <= d;
               if (ix == PW'(V4_ADDR1)) hdr_r <= 1'b1;
            end
            if (net_r == NET_V6) begin
               if (ix == PW'(18)) len_r[15:8] <= d;
               if (ix == PW'(19)) len_r[7:0]  <= d;
               if (ix == PW'(20)) proto_r <= d;
               if (ix == PW'(V6_ADDR1)) hdr_r <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rxck_accum.sv
module rxck_accum
   import rxck_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic              sof,
   input  logic              add_en,
   input  logic              add_hi,
   input  logic [BYTE_W-1:0] d,
   output logic [ACC_W-1:0]  acc_nxt
);
   logic [ACC_W-1:0] acc_r;
   logic [15:0]      word;

   assign word    = add_hi ? {d, 8'h00} : {8'h00, d};
   assign acc_nxt = (sof ? '0 : acc_r) + (add_en ? ACC_W'(word) : '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    acc_r <= '0;
      else if (beat) acc_r <= acc_nxt;
   end
endmodule

// File: rtl/rxck_fold.sv
module rxck_fold #(
   parameter int ACC_W = 32
) (
   input  logic [ACC_W-1:0] x,
   output logic [15:0]      y
);
   localparam int NF = (ACC_W + 15) / 16 + 1;

   logic [ACC_W-1:0] st [NF+1];

   assign st[0] = x;
   generate
      for (genvar k = 0; k < NF; k++) begin : g_fold
         assign st[k+1] = ACC_W'(st[k][15:0]) + (st[k] >> 16);
      end
   endgenerate
   assign y = st[NF][15:0];
endmodule

// File: rtl/rxck_l4_verify.sv
module rxck_l4_verify
   import rxck_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int ACC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic              s_valid,
   input  logic              s_sof,
   input  logic              s_eof,
   input  logic [7:0]        s_data,
   output logic              m_valid,
   output logic              m_sof,
   output logic              m_eof,
   output logic [7:0]        m_data,
   output logic              stat_valid,
   output logic [20:0]       stat_word
);
   generate
      if (CNT_W < 7) begin : g_bad_cnt
         $error("CNT_W must reach byte index 54");
      end
      if (ACC_W < CNT_W + 18) begin : g_bad_acc
         $error("ACC_W too narrow for the longest frame");
      end
   endgenerate

   logic              sof_q, add_en, add_hi, frag, hdr_ok, ck_nz;
   net_e              net;
   logic [7:0]        proto;
   logic [15:0]       l4_len, sum;
   logic [ACC_W-1:0]  acc_nxt, total;
   logic [STAT_W-1:0] word_nxt;
   logic              is_tcp, is_udp, known, udp_exempt, last;

   assign sof_q = s_valid && s_sof;
   assign last  = s_valid && s_eof;

   rxck_hdr_parse #(.CNT_W(CNT_W)) u_parse (
      .clk(clk), .rst_n(rst_n), .beat(s_valid), .sof(sof_q), .d(s_data),
      .add_en(add_en), .add_hi(add_hi), .net(net), .proto(proto),
      .l4_len(l4_len), .frag(frag), .hdr_ok(hdr_ok), .ck_nz(ck_nz)
   );

   rxck_accum #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .beat(s_valid), .sof(sof_q),
      .add_en(add_en), .add_hi(add_hi), .d(s_data), .acc_nxt(acc_nxt)
   );

   assign total = acc_nxt + ACC_W'(proto) + ACC_W'(l4_len);

   rxck_fold #(.ACC_W(ACC_W)) u_fold (.x(total), .y(sum));

   assign is_tcp     = (proto == PR_TCP);
   assign is_udp     = (proto == PR_UDP);
   assign known      = chk_en && hdr_ok && (net != NET_NONE) && (is_tcp || is_udp);
   assign udp_exempt = (net == NET_V4) && is_udp && !ck_nz;

   always_comb begin
      word_nxt = '0;
      if (known) begin
         word_nxt[B_V4]  = (net == NET_V4);
         word_nxt[B_V6]  = (net == NET_V6);
         word_nxt[B_TCP] = is_tcp;
         if (frag) begin
            word_nxt[B_FRAG] = 1'b1;
         end else begin
            word_nxt[15:0]  = sum;
            word_nxt[B_ERR] = (sum != 16'hFFFF) && !udp_exempt;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0; m_sof <= 1'b0; m_eof <= 1'b0; m_data <= '0;
         stat_valid <= 1'b0; stat_word <= '0;
      end else begin
         m_valid    <= s_valid;
         m_sof      <= s_valid && s_sof;
         m_eof      <= s_valid && s_eof;
         m_data     <= s_data;
         stat_valid <= last;
         if (last) stat_word <= word_nxt;
      end
   end
endmodule

// File: rtl/rxck_l4_verify_chk.sv
module rxck_l4_verify_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        chk_en,
   input logic        s_valid,
   input logic        s_eof,
   input logic [7:0]  s_data,
   input logic        m_valid,
   input logic [7:0]  m_data,
   input logic        stat_valid,
   input logic [20:0] stat_word
);
   a_r1_beat_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid |=> (m_valid && m_data == $past(s_data)));
   a_r1_idle_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |=> !m_valid);
   a_r2_stat_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_eof) |=> stat_valid);
   a_r2_stat_only_end: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_valid && s_eof) |=> !stat_valid);
   a_r3_one_version: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> !(stat_word[19] && stat_word[20]));
   a_r4_tcp_needs_ip: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_word[18]) |-> (stat_word[19] || stat_word[20]));
   a_r6_err_means_bad_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_word[16]) |-> (stat_word[15:0] != 16'hFFFF));
   a_r8_frag_no_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_word[17]) |-> (stat_word[16:0] == 17'h0 && stat_word[20]));
   a_r10_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_eof && !chk_en) |=> (stat_word == 21'h0));
endmodule

bind rxck_l4_verify rxck_l4_verify_chk u_chk (
   .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .s_valid(s_valid), .s_eof(s_eof),
   .s_data(s_data), .m_valid(m_valid), .m_data(m_data),
   .stat_valid(stat_valid), .stat_word(stat_word)
);

// File: tb/tb_rxck_l4_verify.sv
`timescale 1ns/1ps
module tb_rxck_l4_verify;
   logic clk = 1'b0, rst_n = 1'b0, chk_en = 1'b1;
   logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
   logic [7:0] s_data = '0;
   logic m_valid, m_sof, m_eof, stat_valid;
   logic [7:0] m_data;
   logic [20:0] stat_word;

   always #10 clk = ~clk;

   rxck_l4_verify dut (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .s_valid(s_valid), .s_sof(s_sof),
      .s_eof(s_eof), .s_data(s_data), .m_valid(m_valid), .m_sof(m_sof), .m_eof(m_eof),
      .m_data(m_data), .stat_valid(stat_valid), .stat_word(stat_word)
   );

   int n_chk = 0, n_bad = 0;
   logic [7:0] fr [0:399];
   int g_ip, g_proto, g_l4s, g_l4len, g_flen;
   bit g_frag, g_short, g_en;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_sum();
      logic [31:0] t = 0;
      int a0 = (g_ip == 6) ? 22 : 26;
      int a1 = (g_ip == 6) ? 53 : 33;
      for (int a = a0; a < a1; a += 2) t += {16'h0, fr[a], fr[a+1]};
      t += 32'(g_proto);
      t += 32'(g_l4len);
      for (int k = 0; k < g_l4len; k += 2)
         t += {16'h0, fr[g_l4s+k], (k + 1 < g_l4len) ? fr[g_l4s+k+1] : 8'h00};
      while (t[31:16] != 0) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
      return t[15:0];
   endfunction

   function automatic logic [20:0] exp_word();
      logic [20:0] w = '0;
      logic [15:0] s;
      bit ckz;
      if (!g_en || g_short || g_ip == 0 || !(g_proto == 6 || g_proto == 17)) return '0;
      w[20] = (g_ip == 4);
      w[19] = (g_ip == 6);
      w[18] = (g_proto == 6);
      if (g_frag) w[17] = 1'b1;
      else begin
         s = ref_sum();
         ckz = (g_ip == 4) && (g_proto == 17) && fr[g_l4s+6] == 0 && fr[g_l4s+7] == 0;
         w[15:0] = s;
         w[16] = (s != 16'hFFFF) && !ckz;
      end
      return w;
   endfunction

   // ip: 4, 6 or 0 (foreign type); fk: 0 none, 1 more-fragments, 2 offset
   task automatic build(int ip, int proto, int ihl, int l4len, int pad, int fk,
                        bit corrupt, bit zck);
      int ckoff;
      logic [15:0] s;
      g_ip = ip; g_proto = proto; g_l4len = l4len; g_frag = (fk != 0); g_short = 0;
      for (int i = 0; i < 400; i++) fr[i] = 8'($urandom);
      {fr[12], fr[13]} = (ip == 4) ? 16'h0800 : (ip == 6) ? 16'h86DD : 16'h0806;
      if (ip != 6) begin
         fr[14] = 8'h40 | 8'(ihl);
         fr[15] = 8'h00;
         {fr[16], fr[17]} = 16'(ihl * 4 + l4len);
         fr[20] = (fk == 1) ? 8'h20 : 8'h40;
         fr[21] = (fk == 2) ? 8'h08 : 8'h00;
         fr[23] = 8'(proto);
         g_l4s = 14 + ihl * 4;
      end else begin
         fr[14] = 8'h60;
         {fr[18], fr[19]} = 16'(l4len);
         fr[20] = 8'(proto);
         g_l4s = 54;
      end
      if (proto == 17) {fr[g_l4s+4], fr[g_l4s+5]} = 16'(l4len);
      ckoff = (proto == 6) ? 16 : 6;
      {fr[g_l4s+ckoff], fr[g_l4s+ckoff+1]} = 16'h0;
      s = ref_sum();
      {fr[g_l4s+ckoff], fr[g_l4s+ckoff+1]} = zck ? 16'h0 : ~s;
      if (corrupt) fr[g_l4s + int'($urandom % l4len)] ^= 8'h5A;
      g_flen = g_l4s + l4len + pad;
   endtask

   task automatic send(string req);
      bit pt_ok = 1;
      logic [20:0] e;
      for (int i = 0; i < g_flen; i++) begin
         @(negedge clk);
         if (i > 0 && !(m_valid && m_data == fr[i-1] && m_sof == (i == 1) && !m_eof)) pt_ok = 0;
         chk_en  = g_en;
         s_valid = 1'b1;
         s_sof   = (i == 0);
         s_eof   = (i == g_flen - 1);
         s_data  = fr[i];
      end
      @(negedge clk);
      if (!(m_valid && m_data == fr[g_flen-1] && m_eof)) pt_ok = 0;
      s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
      chk(pt_ok, "R1 passthrough", 32'(m_data), 32'(fr[g_flen-1]));
      chk(stat_valid == 1'b1, "R2 strobe", 32'(stat_valid), 32'd1);
      e = exp_word();
      chk(stat_word == e, req, 32'(stat_word), 32'(e));
      @(negedge clk);
      chk(stat_valid == 1'b0 && m_valid == 1'b0, "R2 one cycle", 32'(stat_valid), 32'd0);
   endtask

   initial begin
      #(200000 * 20);
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      g_en = 1;
      repeat (3) @(negedge clk);
      chk(m_valid == 0 && stat_valid == 0 && stat_word == 0, "reset", 32'(stat_word), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      build(4, 6, 5, 40, 0, 0, 0, 0);   send("R5 v4 tcp good");
      build(6, 17, 5, 30, 0, 0, 0, 0);  send("R3 v6 udp good");
      build(4, 17, 5, 24, 0, 0, 0, 0);  send("R4 v4 udp flags");
      build(6, 6, 5, 36, 0, 0, 1, 0);   send("R6 v6 tcp corrupt");
      build(4, 6, 5, 28, 0, 0, 1, 0);   send("R6 v4 tcp corrupt");
      build(4, 17, 5, 20, 0, 0, 1, 1);  send("R7 v4 udp zero checksum");
      build(6, 17, 5, 20, 0, 0, 0, 1);  send("R7 v6 udp zero checksum");
      build(4, 6, 5, 32, 0, 1, 0, 0);   send("R8 more-fragments");
      build(4, 17, 5, 16, 0, 2, 0, 0);  send("R8 fragment offset");
      build(0, 6, 5, 30, 0, 0, 0, 0);   send("R9 foreign type");
      build(4, 6, 5, 30, 0, 0, 0, 0);   g_flen = 30; g_short = 1; send("R9 short frame");
      build(4, 1, 5, 20, 0, 0, 0, 0);   send("R4 other protocol");
      build(4, 6, 5, 30, 0, 0, 0, 0);   fr[14] = 8'h65; g_ip = 0; send("R3 version mismatch");
      g_en = 0;
      build(4, 6, 5, 30, 0, 0, 1, 0);   send("R10 disabled");
      g_en = 1;
      build(4, 17, 8, 25, 5, 0, 0, 0);  send("R11 options and padding");
      build(4, 6, 7, 33, 3, 0, 1, 0);   send("R11 options odd length");
      build(6, 17, 5, 9, 4, 0, 0, 0);   send("R5 odd length padded");

      for (int n = 0; n < 60; n++) begin
         int ip    = ($urandom % 2) ? 6 : 4;
         int proto = ($urandom % 2) ? 6 : 17;
         int len   = ((proto == 6) ? 20 : 8) + int'($urandom % 70);
         int fk    = (ip == 4 && ($urandom % 8) == 0) ? 1 + int'($urandom % 2) : 0;
         build(ip, proto, 5 + int'($urandom % 4), len, int'($urandom % 6), fk,
               ($urandom % 3) == 0, ($urandom % 10) == 0);
         send("R5 random");
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule